// File: doc/BRIEF.md
# Sticky Error Capture Bank with Attention Classification

This block collects hardware error pulses into a 64-bit sticky capture register. Each captured error that is not masked is sorted into one of three attention classes: checkstop, recoverable or unit-checkstop. The class comes from a two-bit code built from the matching bits of two action registers. Each class drives its own output pin, so the block raises three separate attention lines instead of one interrupt.

Software reaches the registers through a single-cycle address/data port with eight offsets. Captured bits are cleared through an AND-write alias of the capture register. Mask bits are cleared through an AND-write alias of the mask and set through an OR-write alias. The two action registers are plain read/write registers. These aliases let software change selected bits without a read-modify-write race against bits that hardware sets at the same time.

Only the upper 52 field positions (bits 0 to 51, where bit 0 is the most significant bit of the word) carry error sources. The low twelve positions are tied to zero in every register.

Every port in this block is plain control or status: writes complete in the cycle they are presented and the error inputs are level samples. No interface carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `fault_capture_bank`

## Requirements
- R1: After reset the capture register and both action registers read zero, the mask reads ones in bits 0..51 (0xFFFF_FFFF_FFFF_F000), and all three attention outputs are low.
- R2: On every rising clock edge each high `err_in` bit is ORed into the capture register, and it stays set until software clears it. Field bit k is vector index k, so bit 0 is the MSB.
- R3: A write to offset 1 replaces the capture register with its old value ANDed with the written data. When the same bit is captured and cleared in one cycle, the bit ends up set.
- R4: The mask reads at offset 3. A write to offset 4 ANDs the mask with the data, and a write to offset 5 ORs the data into the mask.
- R5: Offsets 6 (action A) and 7 (action B) are plain read/write registers.
- R6: `attn_cs` is high exactly when some captured, unmasked bit has action code A=0,B=0.
- R7: `attn_rec` is high exactly when some captured, unmasked bit has code A=0,B=1.
- R8: `attn_ucs` is high exactly when some captured, unmasked bit has code A=1,B=1.
- R9: A captured bit with code A=1,B=0 raises no attention output. A captured bit that is masked raises no attention output, but it still reads back as set.
- R10: Bits 52..63 read zero in every register, never capture, and ignore written data.
- R11: Reads from offsets 1, 2, 4 and 5 return zero. Writes to offsets 0, 2 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_in | input | 64 | Error pulse per field bit, index 0 = bit 0 (MSB) |
| reg_wr | input | 1 | Write strobe for the register port, applied on the next edge |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational from register state |
| attn_cs | output | 1 | Checkstop attention |
| attn_rec | output | 1 | Recoverable attention |
| attn_ucs | output | 1 | Unit-checkstop attention |

## Verification
The bench drives an error pulse into a bit in the same cycle that an AND write clears that bit. A design that gives the clear priority would lose the error, and the later read would show zero. Four bits are set up with one action code each and then injected one at a time. This exposes a swapped action register, a decode of the wrong code, and the reserved A=1,B=0 code raising an attention. Further stimulus covers the low twelve positions, the aliases that must read zero, and the offsets whose writes must be dropped. A design that stores unused bits, or decodes an AND alias as a plain write, would then show nonzero read data or a damaged mask.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_CAP      = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_CAP_AND  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_MASK     = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_MASK_AND = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_MASK_OR  = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_ACT_A    = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_ACT_B    = 3'd7;

  typedef struct packed {
    logic cs;
    logic rec;
    logic ucs;
  } attn_t;
endpackage

// File: rtl/fcb_capture.sv
module fcb_capture #(
  parameter int DW = 64,
  parameter logic [0:DW-1] LIVE_VEC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [0:DW-1] err_in,
  input  logic          and_wr,
  input  logic [0:DW-1] wdata,
  output logic [0:DW-1] cap_q
);
  logic [0:DW-1] keep;
  logic [0:DW-1] cap_d;

  // Clear first, then OR in new errors, so a capture beats a clear.
  always_comb begin
    keep  = and_wr ? wdata : '1;
    cap_d = ((cap_q & keep) | err_in) & LIVE_VEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end
endmodule

// File: rtl/fcb_mask.sv
module fcb_mask #(
  parameter int DW = 64,
  parameter logic [0:DW-1] LIVE_VEC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          and_wr,
  input  logic          or_wr,
  input  logic [0:DW-1] wdata,
  output logic [0:DW-1] mask_q
);
  logic [0:DW-1] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (and_wr)     mask_d = mask_q & wdata;
    else if (or_wr) mask_d = mask_q | wdata;
    mask_d = mask_d & LIVE_VEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= LIVE_VEC;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/fcb_action.sv
module fcb_action #(
  parameter int DW = 64,
  parameter logic [0:DW-1] LIVE_VEC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [0:DW-1] wdata,
  output logic [0:DW-1] act_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  act_q <= '0;
    else if (wr) act_q <= wdata & LIVE_VEC;
  end
endmodule

// File: rtl/fcb_classify.sv
module fcb_classify
  import fcb_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [0:DW-1] cap,
  input  logic [0:DW-1] mask,
  input  logic [0:DW-1] act_a,
  input  logic [0:DW-1] act_b,
  output attn_t         attn
);
  logic [0:DW-1] pending;

  always_comb begin
    pending  = cap & ~mask;
    attn.cs  = |(pending & ~act_a & ~act_b);
    attn.rec = |(pending & ~act_a &  act_b);
    attn.ucs = |(pending &  act_a &  act_b);
  end
endmodule

// File: rtl/fault_capture_bank.sv
module fault_capture_bank
  import fcb_pkg::*;
#(
  parameter int DW   = 64,
  parameter int LIVE = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [0:DW-1]     err_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [0:DW-1]     reg_wdata,
  output logic [0:DW-1]     reg_rdata,
  output logic              attn_cs,
  output logic              attn_rec,
  output logic              attn_ucs
);
  function automatic logic [0:DW-1] live_pattern();
    logic [0:DW-1] v;
    for (int i = 0; i < DW; i++) v[i] = (i < LIVE);
    return v;
  endfunction

  localparam logic [0:DW-1] LIVE_VEC = live_pattern();
  localparam int N_ACT = 2;

  logic [0:DW-1] cap_q, mask_q;
  logic [0:DW-1] act_q [N_ACT];
  attn_t         attn;

  fcb_capture #(.DW(DW), .LIVE_VEC(LIVE_VEC)) u_capture (
    .clk(clk), .rst_n(rst_n), .err_in(err_in),
    .and_wr(reg_wr && reg_addr == OFF_CAP_AND),
    .wdata(reg_wdata), .cap_q(cap_q)
  );

  fcb_mask #(.DW(DW), .LIVE_VEC(LIVE_VEC)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .and_wr(reg_wr && reg_addr == OFF_MASK_AND),
    .or_wr(reg_wr && reg_addr == OFF_MASK_OR),
    .wdata(reg_wdata), .mask_q(mask_q)
  );

  for (genvar g = 0; g < N_ACT; g++) begin : g_act
    localparam logic [ADDR_W-1:0] MY_OFF = OFF_ACT_A + ADDR_W'(g);
    fcb_action #(.DW(DW), .LIVE_VEC(LIVE_VEC)) u_act (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr && reg_addr == MY_OFF),
      .wdata(reg_wdata), .act_q(act_q[g])
    );
  end

  fcb_classify #(.DW(DW)) u_classify (
    .cap(cap_q), .mask(mask_q), .act_a(act_q[0]), .act_b(act_q[1]),
    .attn(attn)
  );

  always_comb begin
    case (reg_addr)
      OFF_CAP:   reg_rdata = cap_q;
      OFF_MASK:  reg_rdata = mask_q;
      OFF_ACT_A: reg_rdata = act_q[0];
      OFF_ACT_B: reg_rdata = act_q[1];
      default:   reg_rdata = '0;
    endcase
  end

  assign attn_cs  = attn.cs;
  assign attn_rec = attn.rec;
  assign attn_ucs = attn.ucs;
endmodule

// File: rtl/fcb_checker.sv
module fcb_checker
  import fcb_pkg::*;
#(
  parameter int DW   = 64,
  parameter int LIVE = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic [0:DW-1]     err_in,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [0:DW-1]     reg_wdata,
  input logic [0:DW-1]     cap,
  input logic [0:DW-1]     mask,
  input logic [0:DW-1]     act_a,
  input logic [0:DW-1]     act_b,
  input logic              attn_cs,
  input logic              attn_rec,
  input logic              attn_ucs
);
  function automatic logic [0:DW-1] live_pattern();
    logic [0:DW-1] v;
    for (int i = 0; i < DW; i++) v[i] = (i < LIVE);
    return v;
  endfunction
  localparam logic [0:DW-1] LIVE_VEC = live_pattern();

  // R2
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFF_CAP_AND) |=> ((cap & $past(cap)) == $past(cap)));

  // R2
  error_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_in & LIVE_VEC)) |=> ((cap & $past(err_in & LIVE_VEC)) == $past(err_in & LIVE_VEC)));

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_MASK_OR) |=>
      ((mask & $past(reg_wdata & LIVE_VEC)) == $past(reg_wdata & LIVE_VEC)));

  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap | mask | act_a | act_b) & ~LIVE_VEC) == '0);

  // R6
  cs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attn_cs |-> ((cap & ~mask) != '0));

  // R9
  quiet_attn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap & ~mask & ~(act_a & ~act_b)) == '0) |-> !(attn_cs || attn_rec || attn_ucs));
endmodule

bind fault_capture_bank fcb_checker #(.DW(DW), .LIVE(LIVE)) u_fcb_checker (
  .clk(clk), .rst_n(rst_n), .err_in(err_in), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cap(cap_q), .mask(mask_q),
  .act_a(act_q[0]), .act_b(act_q[1]),
  .attn_cs(attn_cs), .attn_rec(attn_rec), .attn_ucs(attn_ucs)
);

// File: tb/fault_capture_bank_bench.sv
module fault_capture_bank_bench;
  localparam logic [63:0] LIVE_M = 64'hFFFF_FFFF_FFFF_F000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [0:63] err_in = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [0:63] reg_wdata = '0;
  logic [0:63] reg_rdata;
  logic        attn_cs, attn_rec, attn_ucs;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_capture_bank u_fault_capture_bank (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .attn_cs(attn_cs), .attn_rec(attn_rec), .attn_ucs(attn_ucs)
  );

  function automatic logic [63:0] b(int k);
    return 64'h8000_0000_0000_0000 >> k;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic pulse(logic [63:0] e);
    @(negedge clk);
    err_in = e;
    @(negedge clk);
    err_in = '0;
  endtask

  task automatic chk_attn(string req, logic [2:0] exp);
    #2 check(req, {61'd0, attn_cs, attn_rec, attn_ucs}, {61'd0, exp});
  endtask

  task automatic t_reset();
    logic [63:0] d;
    rd(3'd0, d); check("R1 capture", d, 64'd0);
    rd(3'd3, d); check("R1 mask", d, LIVE_M);
    rd(3'd6, d); check("R1 actA", d, 64'd0);
    rd(3'd7, d); check("R1 actB", d, 64'd0);
    chk_attn("R1 attn", 3'b000);
  endtask

  task automatic t_capture();
    logic [63:0] d;
    pulse(b(2) | b(40) | b(60));
    rd(3'd0, d); check("R2 R10 capture", d, b(2) | b(40));
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R2 sticky", d, b(2) | b(40));
  endtask

  task automatic t_clear();
    logic [63:0] d;
    wr(3'd1, ~b(2));
    rd(3'd0, d); check("R3 and-clear", d, b(40));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = '0; err_in = b(2);
    @(negedge clk);
    reg_wr = 1'b0; err_in = '0;
    rd(3'd0, d); check("R3 capture wins", d, b(2));
    wr(3'd1, 64'd0);
    rd(3'd0, d); check("R3 clear all", d, 64'd0);
  endtask

  task automatic t_mask();
    logic [63:0] d;
    wr(3'd4, ~(b(2) | b(9)));
    rd(3'd3, d); check("R4 and-mask", d, LIVE_M & ~(b(2) | b(9)));
    wr(3'd5, b(9));
    rd(3'd3, d); check("R4 or-mask", d, LIVE_M & ~b(2));
    wr(3'd5, '1);
    rd(3'd3, d); check("R4 R10 or-all", d, LIVE_M);
  endtask

  task automatic t_action();
    logic [63:0] d;
    wr(3'd6, 64'hA5A5_5A5A_0FF0_1234);
    wr(3'd7, 64'h1357_9BDF_2468_ACE0);
    rd(3'd6, d); check("R5 R10 actA", d, 64'hA5A5_5A5A_0FF0_1000);
    rd(3'd7, d); check("R5 R10 actB", d, 64'h1357_9BDF_2468_A000);
  endtask

  task automatic t_classify();
    logic [63:0] d;
    wr(3'd4, ~(b(1) | b(2) | b(3) | b(4)));
    wr(3'd6, b(3) | b(4));
    wr(3'd7, b(2) | b(3));
    pulse(b(4)); chk_attn("R9 code A1B0", 3'b000);
    wr(3'd1, 64'd0);
    pulse(b(1)); chk_attn("R6 checkstop", 3'b100);
    wr(3'd1, 64'd0);
    pulse(b(2)); chk_attn("R7 recoverable", 3'b010);
    wr(3'd1, 64'd0);
    pulse(b(3)); chk_attn("R8 unit-checkstop", 3'b001);
    wr(3'd1, 64'd0);
    chk_attn("R3 attn drops after clear", 3'b000);
    pulse(b(10)); chk_attn("R9 masked", 3'b000);
    rd(3'd0, d); check("R9 masked captured", d, b(10));
    wr(3'd1, 64'd0);
  endtask

  task automatic t_undef();
    logic [63:0] d;
    pulse(b(7));
    wr(3'd0, 64'd0);
    rd(3'd0, d); check("R11 write offset0", d, b(7));
    wr(3'd2, 64'd0);
    wr(3'd3, 64'd0);
    rd(3'd3, d); check("R11 write offset3", d, LIVE_M & ~(b(1) | b(2) | b(3) | b(4)));
    rd(3'd6, d); check("R11 actA intact", d, b(3) | b(4));
    rd(3'd1, d); check("R11 read offset1", d, 64'd0);
    rd(3'd2, d); check("R11 read offset2", d, 64'd0);
    rd(3'd4, d); check("R11 read offset4", d, 64'd0);
    rd(3'd5, d); check("R11 read offset5", d, 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_clear();
    t_mask();
    t_action();
    t_classify();
    t_undef();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule